// File: doc/BRIEF.md
# DDR Bank Precharge Timing Tracker

This block follows the life of a single SDRAM bank inside a memory controller. The scheduler presents one command pulse per cycle (activate, read, write, precharge or burst stop), with a per-command flag that requests auto precharge on reads and writes. The block reports whether the bank holds an open row. It also gives a registered ready bit that tells the scheduler whether the bank can take a new command in the next cycle.

When auto precharge is requested, the block schedules the bank's own precharge. It fires at the first cycle where the burst has finished and the minimum activate-to-precharge time has run out. After that it blocks the bank until the row precharge time has passed. Timing values are cycle counts loaded through a configuration strobe. Any command that breaks the bank's rules is dropped and raises a sticky error flag.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset, bank_open is 0, cmd_ready is 1, err_flag is 0 and ap_start is 0.
- R2: An activate sent while the bank is closed and cmd_ready is 1 sets bank_open in the following cycle.
- R3: A read or write with cmd_ap low leaves the row open and cmd_ready high; the flag has no effect on later commands.
- R4: A read or write with cmd_ap high drops cmd_ready from the next cycle. The internal precharge fires at clock edge max(C + B/2, A + tRAS), where C is the command's edge, A is the activate edge and B is the configured burst length in words. At that edge bank_open falls and ap_start pulses high for one cycle.
- R5: After a precharge takes effect at edge P (explicit or internal), cmd_ready stays low until an activate at edge P + tRP is legal; a command before then is refused.
- R6: An explicit precharge to an open bank is legal only at an edge at least tRAS cycles after the activate. A precharge to a closed, ready bank is a harmless no-op.
- R7: A burst stop is legal only while a read without auto precharge is within its B/2 transfer cycles. It ends that burst, leaves the row open and raises no error.
- R8: An illegal command is ignored and sets err_flag, which then holds until reset. Illegal commands include: a read, write, precharge or burst stop that breaks its rule; any command while cmd_ready is 0; and more than one command pulse in a cycle.
- R9: With cfg_we high, cfg_tras, cfg_trp and cfg_burst are taken in; burst lengths of 4 and 8 words (B/2 = 2 or 4 cycles) set the burst window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load timing configuration |
| cfg_tras | input | 8 | Minimum activate-to-precharge, cycles |
| cfg_trp | input | 8 | Precharge-to-activate time, cycles |
| cfg_burst | input | 4 | Burst length in data words |
| cmd_act | input | 1 | Activate pulse |
| cmd_rd | input | 1 | Read pulse |
| cmd_wr | input | 1 | Write pulse |
| cmd_pre | input | 1 | Explicit precharge pulse |
| cmd_bst | input | 1 | Burst stop pulse |
| cmd_ap | input | 1 | Auto precharge with this read or write |
| bank_open | output | 1 | A row is open |
| cmd_ready | output | 1 | A command may be issued next cycle |
| err_flag | output | 1 | Sticky illegal-command flag |
| ap_start | output | 1 | One-cycle pulse: internal precharge started |

## Verification
The internal precharge and a refused command can land in the same cycle. The bench provokes this by issuing a read at the exact edge where a pending auto precharge becomes legal under tRAS. It then expects the bank to close with ap_start high and err_flag set, and it expects the read to leave no trace. The stimulus table also places the burst end before and after the tRAS limit, so that each of the two terms of the firing rule decides the firing edge in turn.

// File: rtl/ddr_bank_pkg.sv
package ddr_bank_pkg;
  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECH  = 2'd2
  } bank_st_t;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic bst;
  } bank_cmd_t;
endpackage

// File: rtl/ddr_bank_cfg.sv
module ddr_bank_cfg #(
  parameter int TW = 8,
  parameter int BLW = 4,
  parameter int DEF_TRAS = 5,
  parameter int DEF_TRP = 3,
  parameter int DEF_BURST = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [TW-1:0]  cfg_tras,
  input  logic [TW-1:0]  cfg_trp,
  input  logic [BLW-1:0] cfg_burst,
  output logic [TW-1:0]  tras,
  output logic [TW-1:0]  trp,
  output logic [BLW-1:0] burst_last
);
  logic [TW-1:0]  tras_q, trp_q;
  logic [BLW-1:0] burst_q;
  logic [BLW-1:0] half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tras_q  <= TW'(DEF_TRAS);
      trp_q   <= TW'(DEF_TRP);
      burst_q <= BLW'(DEF_BURST);
    end else if (cfg_we) begin
      tras_q  <= cfg_tras;
      trp_q   <= cfg_trp;
      burst_q <= cfg_burst;
    end
  end

  always_comb begin
    half = burst_q >> 1;
    if (half == '0) half = BLW'(1);
    burst_last = half - BLW'(1);
  end

  assign tras = tras_q;
  assign trp  = trp_q;
endmodule

// File: rtl/ddr_bank_ras.sv
module ddr_bank_ras #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] tras,
  output logic          ras_ok
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  logic [TW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != CNT_MAX);
    cnt_n  = restart ? TW'(1) : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign ras_ok = (cnt_q >= tras);
endmodule

// File: rtl/ddr_bank_burst.sv
module ddr_bank_burst #(
  parameter int BLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_rd,
  input  logic           stop,
  input  logic [BLW-1:0] last,
  output logic           burst_end,
  output logic           rd_active
);
  logic [BLW-1:0] cnt_q, cnt_n;
  logic           busy_q, busy_n, rd_q, rd_n;
  logic           en;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    rd_n   = rd_q;
    if (start) begin
      cnt_n  = last;
      busy_n = 1'b1;
      rd_n   = start_rd;
    end else if (stop) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - BLW'(1);
    end
    en = start || stop || busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      rd_q   <= rd_n;
    end
  end

  assign burst_end = !busy_q || (cnt_q == '0);
  assign rd_active = busy_q && rd_q;
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_bank_pkg::*;
#(
  parameter int TW = 8,
  parameter int BLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [TW-1:0]  cfg_tras,
  input  logic [TW-1:0]  cfg_trp,
  input  logic [BLW-1:0] cfg_burst,
  input  logic           cmd_act,
  input  logic           cmd_rd,
  input  logic           cmd_wr,
  input  logic           cmd_pre,
  input  logic           cmd_bst,
  input  logic           cmd_ap,
  output logic           bank_open,
  output logic           cmd_ready,
  output logic           err_flag,
  output logic           ap_start
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bank_cmd_t      cmd;
  logic [TW-1:0]  tras, trp;
  logic [BLW-1:0] burst_last;
  logic           ras_ok, burst_end, rd_active;

  bank_st_t       st_q, st_n;
  logic [TW-1:0]  trp_q, trp_n;
  logic           ap_pend_q, ap_pend_n;
  logic           ready_q, ready_n;
  logic           err_q, err_n;
  logic           aps_q, aps_n;

  logic single, any_cmd;
  logic legal_act, legal_rw, legal_pre, legal_bst, illegal, ap_go;
  logic state_en;

  assign cmd = '{act: cmd_act, rd: cmd_rd, wr: cmd_wr, pre: cmd_pre, bst: cmd_bst};

  ddr_bank_cfg #(.TW(TW), .BLW(BLW)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_burst(cfg_burst),
    .tras(tras), .trp(trp), .burst_last(burst_last)
  );

  ddr_bank_ras #(.TW(TW)) u_ras (
    .clk(clk), .rst_n(rst_sync_n), .restart(legal_act),
    .tras(tras), .ras_ok(ras_ok)
  );

  ddr_bank_burst #(.BLW(BLW)) u_burst (
    .clk(clk), .rst_n(rst_sync_n), .start(legal_rw), .start_rd(cmd.rd),
    .stop(legal_bst), .last(burst_last),
    .burst_end(burst_end), .rd_active(rd_active)
  );

  always_comb begin
    any_cmd   = |cmd;
    single    = ($countones(cmd) == 1);
    legal_act = single && cmd.act && ready_q && (st_q == BK_IDLE);
    legal_rw  = single && (cmd.rd || cmd.wr) && ready_q && (st_q == BK_ACTIVE);
    legal_pre = single && cmd.pre && ready_q &&
                ((st_q == BK_IDLE) || ((st_q == BK_ACTIVE) && ras_ok));
    legal_bst = single && cmd.bst && ready_q && (st_q == BK_ACTIVE) && rd_active;
    illegal   = any_cmd && !(legal_act || legal_rw || legal_pre || legal_bst);
    ap_go     = ap_pend_q && burst_end && ras_ok && (st_q == BK_ACTIVE);
  end

  always_comb begin
    st_n      = st_q;
    trp_n     = trp_q;
    ap_pend_n = ap_pend_q;
    err_n     = err_q || illegal;
    aps_n     = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (legal_act) st_n = BK_ACTIVE;
      end
      BK_ACTIVE: begin
        if (ap_go || legal_pre) begin
          aps_n     = ap_go;
          ap_pend_n = 1'b0;
          if (trp <= TW'(1)) begin
            st_n = BK_IDLE;
          end else begin
            st_n  = BK_PRECH;
            trp_n = trp - TW'(1);
          end
        end else if (legal_rw && cmd_ap) begin
          ap_pend_n = 1'b1;
        end
      end
      BK_PRECH: begin
        trp_n = trp_q - TW'(1);
        if (trp_q <= TW'(1)) st_n = BK_IDLE;
      end
      default: st_n = BK_IDLE;
    endcase
    ready_n  = (st_n != BK_PRECH) && !ap_pend_n;
    state_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= BK_IDLE;
      trp_q     <= '0;
      ap_pend_q <= 1'b0;
      ready_q   <= 1'b1;
      err_q     <= 1'b0;
      aps_q     <= 1'b0;
    end else if (state_en) begin
      st_q      <= st_n;
      trp_q     <= trp_n;
      ap_pend_q <= ap_pend_n;
      ready_q   <= ready_n;
      err_q     <= err_n;
      aps_q     <= aps_n;
    end
  end

  assign bank_open = (st_q == BK_ACTIVE);
  assign cmd_ready = ready_q;
  assign err_flag  = err_q;
  assign ap_start  = aps_q;
endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_act,
  input logic cmd_rd,
  input logic cmd_wr,
  input logic cmd_pre,
  input logic cmd_bst,
  input logic cmd_ap,
  input logic bank_open,
  input logic cmd_ready,
  input logic err_flag,
  input logic ap_start
);
  logic [4:0] cv;
  logic one_cmd, some_cmd;
  assign cv       = {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_bst};
  assign one_cmd  = ($countones(cv) == 1);
  assign some_cmd = (cv != 5'd0);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R4
  ap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |=> !ap_start);

  // R4
  ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |-> !bank_open);

  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_cmd && cmd_act && cmd_ready && !bank_open) |=> bank_open);

  // R4
  ap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_cmd && (cmd_rd || cmd_wr) && cmd_ap && cmd_ready && bank_open) |=> !cmd_ready);

  // R5
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (some_cmd && !cmd_ready) |=> err_flag);

  // R7
  bst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_cmd && cmd_bst && cmd_ready && bank_open) |=> bank_open);
endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .cmd_pre(cmd_pre), .cmd_bst(cmd_bst), .cmd_ap(cmd_ap),
  .bank_open(bank_open), .cmd_ready(cmd_ready),
  .err_flag(err_flag), .ap_start(ap_start)
);

// File: tb/ddr_bank_tracker_test.sv
module ddr_bank_tracker_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [7:0] cfg_tras, cfg_trp;
  logic [3:0] cfg_burst;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_bst, cmd_ap;
  logic bank_open, cmd_ready, err_flag, ap_start;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ddr_bank_tracker uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_burst(cfg_burst),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .cmd_bst(cmd_bst), .cmd_ap(cmd_ap),
    .bank_open(bank_open), .cmd_ready(cmd_ready),
    .err_flag(err_flag), .ap_start(ap_start)
  );

  // command codes: 0 none, 1 act, 2 rd, 3 wr, 4 pre, 5 bst, 6 act+rd together
  // row = {code[2:0], ap, open, ready, err, ap_start}, tRAS 5, tRP 3, burst 4
  localparam logic [7:0] VEC [17] = '{
    8'b001_0_1100, // R2 activate
    8'b010_0_1100, // R3 read, no auto precharge
    8'b101_0_1100, // R7 burst stop inside read burst
    8'b011_1_1000, // R4 write with auto precharge
    8'b000_0_1000,
    8'b000_0_0001, // R4 fires on tRAS edge
    8'b000_0_0000,
    8'b000_0_0100, // R5 ready back after tRP
    8'b001_0_1100,
    8'b010_1_1000, // R4 read with auto precharge, tRAS dominates
    8'b000_0_1000,
    8'b000_0_1000,
    8'b000_0_1000,
    8'b010_0_0011, // R8 refused read in the firing cycle
    8'b000_0_0010,
    8'b000_0_0110, // R5
    8'b001_0_1110
  };

  task automatic drive(input logic [2:0] code, input logic ap);
    cmd_act = (code == 3'd1) || (code == 3'd6);
    cmd_rd  = (code == 3'd2) || (code == 3'd6);
    cmd_wr  = (code == 3'd3);
    cmd_pre = (code == 3'd4);
    cmd_bst = (code == 3'd5);
    cmd_ap  = ap;
  endtask

  task automatic step(input logic [2:0] code, input logic ap);
    drive(code, ap);
    @(posedge clk);
    #1;
    drive(3'd0, 1'b0);
  endtask

  task automatic expect_o(input string tag, input logic eo, input logic er,
                          input logic ee, input logic ea);
    checks++;
    if ({bank_open, cmd_ready, err_flag, ap_start} !== {eo, er, ee, ea}) begin
      errors++;
      $display("FAIL %s open/ready/err/ap actual %b%b%b%b expected %b%b%b%b",
               tag, bank_open, cmd_ready, err_flag, ap_start, eo, er, ee, ea);
    end
  endtask

  task automatic do_reset(input logic [7:0] tras, input logic [7:0] trp,
                          input logic [3:0] burst);
    rst_n = 1'b0;
    cfg_we = 1'b0;
    drive(3'd0, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cfg_tras = tras; cfg_trp = trp; cfg_burst = burst; cfg_we = 1'b1;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cfg_tras = 8'd5; cfg_trp = 8'd3; cfg_burst = 4'd4;
    do_reset(8'd5, 8'd3, 4'd4);
    expect_o("R1 reset state", 1'b0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][7:5], VEC[i][4]);
      expect_o($sformatf("R2-R8 table row %0d", i),
               VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6 precharge before tRAS is refused (R8)
    do_reset(8'd5, 8'd3, 4'd4);
    step(3'd1, 1'b0);
    step(3'd4, 1'b0);
    expect_o("R6 early precharge refused", 1'b1, 1'b1, 1'b1, 1'b0);

    // R6 legal precharge, then R5 early activate refused
    do_reset(8'd5, 8'd3, 4'd4);
    step(3'd1, 1'b0);
    for (int k = 0; k < 4; k++) step(3'd0, 1'b0);
    step(3'd4, 1'b0);
    expect_o("R6 precharge at tRAS", 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd1, 1'b0);
    expect_o("R5 activate inside tRP", 1'b0, 1'b0, 1'b1, 1'b0);
    step(3'd0, 1'b0);
    expect_o("R5 ready after tRP", 1'b0, 1'b1, 1'b1, 1'b0);
    step(3'd1, 1'b0);
    expect_o("R5 activate after tRP", 1'b1, 1'b1, 1'b1, 1'b0);

    // R8 read to a closed bank
    do_reset(8'd5, 8'd3, 4'd4);
    step(3'd2, 1'b0);
    expect_o("R8 read closed bank", 1'b0, 1'b1, 1'b1, 1'b0);

    // R7 burst stop after a write is refused
    do_reset(8'd5, 8'd3, 4'd4);
    step(3'd1, 1'b0);
    step(3'd3, 1'b0);
    expect_o("R3 write keeps row", 1'b1, 1'b1, 1'b0, 1'b0);
    step(3'd5, 1'b0);
    expect_o("R7 stop after write", 1'b1, 1'b1, 1'b1, 1'b0);

    // R8 two commands at once
    do_reset(8'd5, 8'd3, 4'd4);
    step(3'd6, 1'b0);
    expect_o("R8 double command", 1'b0, 1'b1, 1'b1, 1'b0);

    // R9 burst 8, burst end dominates (tRAS 2)
    do_reset(8'd2, 8'd3, 4'd8);
    step(3'd1, 1'b0);
    step(3'd0, 1'b0);
    step(3'd0, 1'b0);
    step(3'd2, 1'b1);
    expect_o("R4 read ap blocks", 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(3'd0, 1'b0);
      expect_o("R9 burst 8 still open", 1'b1, 1'b0, 1'b0, 1'b0);
    end
    step(3'd0, 1'b0);
    expect_o("R9 fire at burst end", 1'b0, 1'b0, 1'b0, 1'b1);

    // R7 stop mid-burst for burst 8, then explicit precharge
    do_reset(8'd5, 8'd3, 4'd8);
    step(3'd1, 1'b0);
    step(3'd2, 1'b0);
    step(3'd0, 1'b0);
    step(3'd5, 1'b0);
    expect_o("R7 stop in burst 8", 1'b1, 1'b1, 1'b0, 1'b0);
    step(3'd0, 1'b0);
    step(3'd4, 1'b0);
    expect_o("R3 row kept until precharge", 1'b0, 1'b0, 1'b0, 1'b0);

    summary();
  end
endmodule